// File: doc/BRIEF.md
# Serial Bit-Rate Clock Enable Generator

This block produces the bit-rate timing for a serial transmitter and receiver. A programmable 12-bit divisor drives a down-counter. The counter makes one base tick every divisor+1 system clocks. The block then turns those ticks, or an external serial clock, into single-cycle transmit and receive enables. It has four operating modes. Plain asynchronous and double-speed asynchronous oversample the line. Synchronous master drives a serial clock pin. Synchronous slave samples that pin from outside and detects its edges.

Three control inputs choose the mode:
- a synchronous-select bit;
- a double-speed bit, which matters only when the synchronous-select bit is low;
- a pin-direction bit, which picks master or slave when synchronous operation is selected.

When the mode changes, the block clears its internal dividers, so no enable comes from a partly counted period. When the divisor is written, the base counter restarts from the new value.

Top module: `usart_clkgen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, txEn, rxEn, clkPinOut and clkPinOe are all 0.
- R2: The base tick recurs every baudDiv+1 system clocks (every clock for baudDiv = 0).
- R3: With syncMode = 0 and dblSpeed = 0, rxEn pulses on every base tick and txEn pulses on every 16th base tick, so txEn has period 16·(baudDiv+1) clocks.
- R4: With syncMode = 0 and dblSpeed = 1, txEn pulses on every 8th base tick, so its period is 8·(baudDiv+1) clocks. rxEn still pulses on every base tick.
- R5: With syncMode = 1 and clkPinDir = 1 (master), clkPinOe is 1 and clkPinOut toggles once per base tick. rxEn pulses in the cycle clkPinOut becomes 1, and txEn pulses in the cycle it becomes 0. txEn and rxEn never pulse together.
- R6: With syncMode = 1 and clkPinDir = 0 (slave), clkPinOe is 0 and clkPinIn passes through a two-flop synchronizer. rxEn pulses three clocks after a rising change of clkPinIn, and txEn pulses three clocks after a falling one.
- R7: In synchronous modes dblSpeed has no effect on any output.
- R8: With syncMode = 0, clkPinOe and clkPinOut stay 0, and clkPinIn has no effect on the outputs.
- R9: A baudWr pulse loads baudDiv into the base counter in that cycle and gives no tick in that cycle. The next tick comes baudDiv+1 clocks later.
- R10: A change of mode clears the oversampling divider and the master clock phase. It suppresses every enable in the cycle of the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncMode | input | 1 | 0 = asynchronous, 1 = synchronous |
| dblSpeed | input | 1 | Halves the transmit oversampling in asynchronous mode |
| clkPinDir | input | 1 | Synchronous clock source: 1 = drive pin (master), 0 = sample pin (slave) |
| baudDiv | input | 12 | Base tick divisor |
| baudWr | input | 1 | Divisor written; restarts the base counter |
| clkPinIn | input | 1 | External serial clock input |
| clkPinOut | output | 1 | Serial clock driven in master mode |
| clkPinOe | output | 1 | Output enable for the serial clock pin |
| txEn | output | 1 | Single-cycle transmit bit enable |
| rxEn | output | 1 | Single-cycle receive sample enable |

## Verification
A divisor of zero is the hardest case. There the base tick fires every clock. A counter that reloads one cycle late, or checks for zero only after it decrements, gives a period of two or never fires at all. The bench switches modes in the middle of a stream and writes the divisor in the middle of a period. A design that does not clear its divider on a mode change gives a short first transmit period. A design that ignores the write keeps the old cadence. Slave runs measure the three-clock delay from pin edge to enable and check which edge drives which enable. A design that swaps the edges or drops a synchronizer stage is off by a cycle on every pulse.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC     = 2'd0,
    MODE_ASYNC_DBL = 2'd1,
    MODE_MASTER    = 2'd2,
    MODE_SLAVE     = 2'd3
  } clkMode_e;

  // strobes from control to the divider datapath
  typedef struct packed {
    logic reload;   // load divisor into base counter, no tick
    logic clrDiv;   // clear oversampler and master phase
    logic dbl;      // double-speed oversampling ratio
    logic master;   // toggle master clock phase on ticks
  } divCtl_t;

  // status from the datapath back to control
  typedef struct packed {
    logic tick;     // base tick this cycle
    logic txTick;   // oversampler wraps on this tick
    logic phase;    // current master clock level
  } divStat_t;

endpackage

// File: rtl/clkgen_div.sv
module clkgen_div
  import usart_clkgen_pkg::*;
#(
  parameter int BAUD_W   = 12,
  parameter int OVS_NORM = 16,
  parameter int OVS_DBL  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BAUD_W-1:0] baudDiv,
  input  divCtl_t           ctl,
  output divStat_t          stat
);

  localparam int PRE_W = $clog2(OVS_NORM);
  localparam logic [PRE_W-1:0] LAST_NORM = PRE_W'(OVS_NORM - 1);
  localparam logic [PRE_W-1:0] LAST_DBL  = PRE_W'(OVS_DBL - 1);

  logic [BAUD_W-1:0] baudCnt;
  logic [PRE_W-1:0]  preCnt;
  logic              phaseQ;
  logic              tick;
  logic [PRE_W-1:0]  preLast;

  assign tick    = (baudCnt == '0) && !ctl.reload;
  assign preLast = ctl.dbl ? LAST_DBL : LAST_NORM;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baudCnt <= '0;
    end else if (ctl.reload || baudCnt == '0) begin
      baudCnt <= baudDiv;
    end else begin
      baudCnt <= baudCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      phaseQ <= 1'b0;
    end else if (ctl.clrDiv) begin
      preCnt <= '0;
      phaseQ <= 1'b0;
    end else if (tick) begin
      preCnt <= (preCnt == preLast) ? '0 : preCnt + 1'b1;
      if (ctl.master) phaseQ <= ~phaseQ;
    end
  end

  assign stat.tick   = tick;
  assign stat.txTick = tick && (preCnt == preLast);
  assign stat.phase  = phaseQ;

  // R2
  reload_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (baudCnt == $past(baudDiv)));

  // R10
  clear_divider_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrDiv |=> (preCnt == '0 && !phaseQ));

  // R4
  dbl_ratio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dbl && !ctl.clrDiv) |-> (preCnt <= LAST_DBL));

  // R5
  master_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && ctl.master && !ctl.clrDiv) |=> (phaseQ != $past(phaseQ)));

endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import usart_clkgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     syncMode,
  input  logic     dblSpeed,
  input  logic     clkPinDir,
  input  logic     baudWr,
  input  logic     clkPinIn,
  input  divStat_t stat,
  output divCtl_t  ctl,
  output logic     clkPinOut,
  output logic     clkPinOe,
  output logic     txEn,
  output logic     rxEn
);

  clkMode_e mode, modeQ;
  logic     modeChg;
  logic [SYNC_STAGES-1:0] syncQ;
  logic     pinPrev, pinNow;
  logic     pinRise, pinFall;
  logic     txNext, rxNext;

  always_comb begin
    if (syncMode) mode = clkPinDir ? MODE_MASTER : MODE_SLAVE;
    else          mode = dblSpeed ? MODE_ASYNC_DBL : MODE_ASYNC;
  end

  assign modeChg = (mode != modeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_ASYNC;
    else       modeQ <= mode;
  end

  // external clock synchronizer chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else if (s == 0) syncQ[s] <= clkPinIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinNow;
  end

  assign pinRise = pinNow && !pinPrev && !modeChg;
  assign pinFall = !pinNow && pinPrev && !modeChg;

  assign ctl.reload = modeChg || baudWr;
  assign ctl.clrDiv = modeChg;
  assign ctl.dbl    = (mode == MODE_ASYNC_DBL);
  assign ctl.master = (mode == MODE_MASTER);

  always_comb begin
    txNext = 1'b0;
    rxNext = 1'b0;
    unique case (mode)
      MODE_ASYNC, MODE_ASYNC_DBL: begin
        txNext = stat.txTick;
        rxNext = stat.tick;
      end
      MODE_MASTER: begin
        txNext = stat.tick && stat.phase;
        rxNext = stat.tick && !stat.phase;
      end
      MODE_SLAVE: begin
        txNext = pinFall;
        rxNext = pinRise;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn <= 1'b0;
      rxEn <= 1'b0;
    end else begin
      txEn <= txNext;
      rxEn <= rxNext;
    end
  end

  assign clkPinOe  = (mode == MODE_MASTER);
  assign clkPinOut = (mode == MODE_MASTER) && stat.phase;

  // R5
  sync_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_MASTER || modeQ == MODE_SLAVE) |-> !(txEn && rxEn));

  // R3
  async_tx_on_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && (modeQ == MODE_ASYNC || modeQ == MODE_ASYNC_DBL)) |-> rxEn);

  // R6
  slave_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxEn && modeQ == MODE_SLAVE) |-> ($past(pinNow) && !$past(pinPrev)));

  // R10
  change_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> (!txEn && !rxEn));

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
  import usart_clkgen_pkg::*;
#(
  parameter int BAUD_W      = 12,
  parameter int OVS_NORM    = 16,
  parameter int OVS_DBL     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncMode,
  input  logic              dblSpeed,
  input  logic              clkPinDir,
  input  logic [BAUD_W-1:0] baudDiv,
  input  logic              baudWr,
  input  logic              clkPinIn,
  output logic              clkPinOut,
  output logic              clkPinOe,
  output logic              txEn,
  output logic              rxEn
);

  divCtl_t  divCtl;
  divStat_t divStat;

  clkgen_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .syncMode  (syncMode),
    .dblSpeed  (dblSpeed),
    .clkPinDir (clkPinDir),
    .baudWr    (baudWr),
    .clkPinIn  (clkPinIn),
    .stat      (divStat),
    .ctl       (divCtl),
    .clkPinOut (clkPinOut),
    .clkPinOe  (clkPinOe),
    .txEn      (txEn),
    .rxEn      (rxEn)
  );

  clkgen_div #(
    .BAUD_W   (BAUD_W),
    .OVS_NORM (OVS_NORM),
    .OVS_DBL  (OVS_DBL)
  ) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .baudDiv (baudDiv),
    .ctl     (divCtl),
    .stat    (divStat)
  );

  // R8
  async_pin_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncMode |-> (!clkPinOe && !clkPinOut));

endmodule

// File: tb/tb_usart_clkgen.sv
module tb_usart_clkgen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        syncMode = 1'b0, dblSpeed = 1'b0, clkPinDir = 1'b0;
  logic [11:0] baudDiv = '0;
  logic        baudWr = 1'b0, clkPinIn = 1'b0;
  logic        clkPinOut, clkPinOe, txEn, rxEn;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  usart_clkgen dut (
    .clk(clk), .rstN(rstN), .syncMode(syncMode), .dblSpeed(dblSpeed),
    .clkPinDir(clkPinDir), .baudDiv(baudDiv), .baudWr(baudWr),
    .clkPinIn(clkPinIn), .clkPinOut(clkPinOut), .clkPinOe(clkPinOe),
    .txEn(txEn), .rxEn(rxEn));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // behavioural reference model, stepped at each falling edge
  int mCnt = 0, mPre = 0, mPhase = 0, mModeQ = 0;
  int mS1 = 0, mS2 = 0, mS3 = 0, mTx = 0, mRx = 0;

  function automatic int curMode();
    if (syncMode) return clkPinDir ? 2 : 3;
    return dblSpeed ? 1 : 0;
  endfunction

  function automatic string reqOf(int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(negedge clk) begin
    int m, tick, chg, reload, ovs, nTx, nRx;
    m = curMode();
    if (cycles >= 2) begin
      if (!rstN) begin
        check("R1", "txEn in reset", txEn, 0);
        check("R1", "rxEn in reset", rxEn, 0);
        check("R1", "clkPinOe in reset", clkPinOe, 0);
      end else begin
        check(reqOf(mModeQ), "txEn", txEn, mTx);
        check(reqOf(mModeQ), "rxEn", rxEn, mRx);
        check((m == 2) ? "R5" : "R8", "clkPinOe", clkPinOe, (m == 2) ? 1 : 0);
        check((m == 2) ? "R5" : "R8", "clkPinOut", clkPinOut, (m == 2) ? mPhase : 0);
      end
    end
    if (!rstN) begin
      mCnt = 0; mPre = 0; mPhase = 0; mModeQ = 0;
      mS1 = 0; mS2 = 0; mS3 = 0; mTx = 0; mRx = 0;
    end else begin
      chg    = (m != mModeQ);
      reload = chg || baudWr;
      tick   = (mCnt == 0) && !reload;
      ovs    = (m == 1) ? 8 : 16;
      nTx = 0; nRx = 0;
      if (m <= 1) begin
        nRx = tick;
        nTx = tick && (mPre == ovs - 1);
      end else if (m == 2) begin
        nRx = tick && (mPhase == 0);
        nTx = tick && (mPhase == 1);
      end else begin
        nRx = !chg && mS2 && !mS3;
        nTx = !chg && !mS2 && mS3;
      end
      mTx = nTx; mRx = nRx;
      if (chg) begin
        mPre = 0; mPhase = 0;
      end else if (tick) begin
        mPre = (mPre + 1) % ovs;
        if (m == 2) mPhase = 1 - mPhase;
      end
      mCnt = (reload || mCnt == 0) ? int'(baudDiv) : mCnt - 1;
      mS3 = mS2; mS2 = mS1; mS1 = clkPinIn;
      mModeQ = m;
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // independent period measurement between two consecutive pulses
  task automatic measure(bit useRx, int exp, string req);
    int n = 0;
    bit got = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ((useRx ? rxEn : txEn) === 1'b1) begin got = 1; break; end
    end
    if (got) begin
      got = 0;
      for (int i = 0; i < 4000; i++) begin
        @(negedge clk);
        n++;
        if ((useRx ? rxEn : txEn) === 1'b1) begin got = 1; break; end
      end
    end
    check(req, useRx ? "rx period" : "tx period", got ? n : -1, exp);
    step(1);
  endtask

  task automatic setMode(bit s, bit d, bit p, int div);
    syncMode = s; dblSpeed = d; clkPinDir = p; baudDiv = 12'(div);
  endtask

  task automatic slaveRun(int half, int toggles);
    for (int i = 0; i < toggles; i++) begin
      clkPinIn = ~clkPinIn;
      step(half);
    end
  endtask

  initial begin
    step(5);
    check("R1", "txEn after reset", txEn, 0);
    check("R1", "clkPinOe after reset", clkPinOe, 0);
    rstN = 1'b1;
    check("R1", "rxEn first cycle", rxEn, 0);

    // R2 R3: divisor zero and three
    setMode(0, 0, 0, 0); step(3);
    measure(1, 1, "R2");
    measure(0, 16, "R3");
    baudDiv = 3; baudWr = 1; step(1); baudWr = 0;
    measure(1, 4, "R2");
    measure(0, 64, "R3");

    // R4: double speed
    setMode(0, 1, 0, 2); step(2);
    measure(0, 24, "R4");
    measure(1, 3, "R4");
    baudDiv = 0; baudWr = 1; step(1); baudWr = 0;
    measure(0, 8, "R4");

    // R8: pin input toggling in async mode has no effect
    setMode(0, 0, 0, 1); step(1);
    for (int i = 0; i < 40; i++) begin clkPinIn = ~clkPinIn; step(1); end
    measure(0, 32, "R8");

    // R9: mid-period write of a new divisor
    baudDiv = 9; baudWr = 1; step(1); baudWr = 0; step(7);
    baudDiv = 1; baudWr = 1; step(1); baudWr = 0;
    measure(1, 2, "R9");

    // R5 R7: master, double speed ignored
    setMode(1, 0, 1, 2); step(1);
    measure(0, 6, "R5");
    dblSpeed = 1;
    measure(0, 6, "R7");
    measure(1, 6, "R7");
    setMode(1, 0, 1, 0); baudWr = 1; step(1); baudWr = 0;
    measure(0, 2, "R5");

    // R10: mode switch mid-stream, then back
    setMode(0, 0, 0, 0); step(5);
    setMode(0, 1, 0, 0); step(1);
    setMode(0, 0, 0, 0); step(3);
    measure(0, 16, "R10");

    // R6 R7: slave with two external clock rates
    setMode(1, 0, 0, 0); clkPinIn = 0; step(4);
    fork slaveRun(3, 30); join_none
    measure(0, 6, "R6");
    measure(1, 6, "R6");
    wait fork;
    dblSpeed = 1; step(3);
    fork slaveRun(5, 30); join_none
    measure(0, 10, "R7");
    wait fork;

    // R10: master to async to master switching
    setMode(1, 0, 1, 4); step(13);
    setMode(0, 0, 0, 4); step(9);
    setMode(1, 0, 1, 4); step(60);

    step(5);
    finishRun();
  end

  initial begin
    while (cycles < 150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finishRun();
  end

endmodule